// File: doc/BRIEF.md
# Frame-Synchronized Video Control Register Shadowing

This block holds the control registers of a tile-based video controller: horizontal and vertical scroll for the background layer, the same pair for the foreground layer, and a layer-enable field. The CPU writes a staging copy through a small register write port. The renderers see only a live copy. The live copy changes only when two conditions meet: video memory has synchronized after a completed DMA transfer, and the display is between frames. A scroll change therefore never lands in the middle of a drawn frame, and a frame cannot tear.

A DMA-complete pulse that arrives while a frame is being drawn is held as a pending commit. The copy then happens on the first cycle of vertical blanking. A pulse that arrives while blanking is already active commits on the next clock edge. Reads return the staging values, so software always sees what it last wrote. A separate status word reports whether a commit is still pending.

The write port is a valid/ready interface that never applies back-pressure. `wr_ready` is held high, and a write is taken on every clock edge where `wr_valid` is high. The read port is combinational and has no handshake.

Top module: `vid_ctrl_shadow`

## Requirements
- R1: After reset, all staging values, all live outputs and the pending flag are zero.
- R2: A write with `wr_valid` high to a mapped word address updates that staging value, masked to the field width, on the clock edge. The mapped byte addresses are 0x00 background X, 0x04 background Y, 0x08 foreground X, 0x0C foreground Y and 0x10 layer enable. The scroll fields are SCROLL_W bits wide and the layer field is LAYER_W bits wide. A read of the same address returns the masked value, zero-extended. The write does not change any live output.
- R3: The live outputs do not change on any clock edge where `vblank` is low.
- R4: Without a DMA-complete pulse, the live outputs stay unchanged even when `vblank` is high.
- R5: A `dma_done` pulse while `vblank` is low sets the pending flag. The flag is visible on `commit_pending` and as bit 0 of a read at address 0x14. On the first clock edge with `vblank` high, the live outputs take the staging values and the pending flag clears.
- R6: A `dma_done` pulse while `vblank` is high commits on that clock edge, and it leaves the pending flag low.
- R7: Writes to a misaligned address (`wr_addr[1:0]` not zero) or to an unmapped word are ignored. The status word at 0x14 is read-only. Reads of misaligned or unmapped addresses return zero.
- R8: When a write and a commit occur on the same edge, the live outputs take the staging values from before that edge, and the staging register takes the new write.
- R9: `wr_ready` is always high, so a write is accepted on every edge where `wr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_W | Staging value or status word at rd_addr |
| dma_done | input | 1 | One-cycle pulse: a DMA transfer has completed |
| vblank | input | 1 | High during vertical blanking |
| bg_scroll_x | output | SCROLL_W | Live background horizontal scroll |
| bg_scroll_y | output | SCROLL_W | Live background vertical scroll |
| fg_scroll_x | output | SCROLL_W | Live foreground horizontal scroll |
| fg_scroll_y | output | SCROLL_W | Live foreground vertical scroll |
| layer_en | output | LAYER_W | Live layer enables |
| commit_pending | output | 1 | A DMA-complete pulse is waiting for blanking |

## Verification
The bench builds the block with its default parameters: SCROLL_W = 9, LAYER_W = 3, ADDR_W = 8 and DATA_W = 32. The 9-bit scroll fields and the 3-bit layer field are small enough that every value of every field is written with junk in the upper bits, then read back, while the live outputs are checked to stay untouched. The 8-bit address space is small enough that all 256 byte addresses are swept. That sweep covers every misaligned and unmapped write and read. The commit sequences are then driven with arithmetic patterns across several frames: a mid-frame pulse, a pulse during blanking, blanking without a pulse, and a write that coincides with a commit.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int NUM_SCROLL = 4;
  localparam int STATUS_IDX = 5;

  typedef enum logic [2:0] {
    FLD_BG_X  = 3'd0,
    FLD_BG_Y  = 3'd1,
    FLD_FG_X  = 3'd2,
    FLD_FG_Y  = 3'd3,
    FLD_LAYER = 3'd4
  } field_e;
endpackage

// File: rtl/vcs_stage.sv
module vcs_stage
  import vcs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int SCROLL_W = 9,
  parameter int LAYER_W  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic                             pending,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0]                rd_data
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             wr_aligned;
  logic             rd_aligned;

  assign wr_idx     = wr_addr[ADDR_W-1:2];
  assign rd_idx     = rd_addr[ADDR_W-1:2];
  assign wr_aligned = (wr_addr[1:0] == 2'b00);
  assign rd_aligned = (rd_addr[1:0] == 2'b00);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int W = (i < NUM_SCROLL) ? SCROLL_W : LAYER_W;
    localparam logic [DATA_W-1:0] MASK = DATA_W'((64'd1 << W) - 64'd1);
    logic hit;
    assign hit = wr_en && wr_aligned && (int'(wr_idx) == i);
    always_ff @(posedge clk) begin
      if (!rst_n)   stage_q[i] <= '0;
      else if (hit) stage_q[i] <= wr_data & MASK;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_aligned) begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (int'(rd_idx) == i) rd_data = stage_q[i];
      end
      if (int'(rd_idx) == STATUS_IDX) rd_data = {{(DATA_W-1){1'b0}}, pending};
    end
  end
endmodule

// File: rtl/vcs_commit.sv
module vcs_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_done,
  input  logic vblank,
  output logic commit,
  output logic pending
);
  logic pend_q;

  assign commit  = vblank && (pend_q || dma_done);
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (commit)              pend_q <= 1'b0;
    else if (dma_done && !vblank) pend_q <= 1'b1;
  end
endmodule

// File: rtl/vcs_live.sv
module vcs_live
  import vcs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SCROLL_W = 9,
  parameter int LAYER_W  = 3,
  localparam int TOT_W   = NUM_SCROLL * SCROLL_W + LAYER_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] stage_q,
  output logic [TOT_W-1:0]                  live_flat
);
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_live
    localparam int W   = (i < NUM_SCROLL) ? SCROLL_W : LAYER_W;
    localparam int OFF = i * SCROLL_W;
    always_ff @(posedge clk) begin
      if (!rst_n)      live_flat[OFF +: W] <= '0;
      else if (commit) live_flat[OFF +: W] <= stage_q[i][W-1:0];
    end
  end
endmodule

// File: rtl/vid_ctrl_shadow.sv
module vid_ctrl_shadow
  import vcs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int SCROLL_W = 9,
  parameter int LAYER_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                dma_done,
  input  logic                vblank,
  output logic [SCROLL_W-1:0] bg_scroll_x,
  output logic [SCROLL_W-1:0] bg_scroll_y,
  output logic [SCROLL_W-1:0] fg_scroll_x,
  output logic [SCROLL_W-1:0] fg_scroll_y,
  output logic [LAYER_W-1:0]  layer_en,
  output logic                commit_pending
);
  localparam int TOT_W = NUM_SCROLL * SCROLL_W + LAYER_W;

  logic [NUM_FIELDS-1:0][DATA_W-1:0] stage_q;
  logic [TOT_W-1:0]                  live_flat;
  logic                              commit;
  logic                              pending;

  assign wr_ready = 1'b1;

  vcs_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SCROLL_W(SCROLL_W), .LAYER_W(LAYER_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_valid && wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .pending(pending),
    .stage_q(stage_q), .rd_data(rd_data)
  );

  vcs_commit u_commit (
    .clk(clk), .rst_n(rst_n), .dma_done(dma_done), .vblank(vblank),
    .commit(commit), .pending(pending)
  );

  vcs_live #(.DATA_W(DATA_W), .SCROLL_W(SCROLL_W), .LAYER_W(LAYER_W)) u_live (
    .clk(clk), .rst_n(rst_n), .commit(commit), .stage_q(stage_q), .live_flat(live_flat)
  );

  assign bg_scroll_x    = live_flat[0*SCROLL_W +: SCROLL_W];
  assign bg_scroll_y    = live_flat[1*SCROLL_W +: SCROLL_W];
  assign fg_scroll_x    = live_flat[2*SCROLL_W +: SCROLL_W];
  assign fg_scroll_y    = live_flat[3*SCROLL_W +: SCROLL_W];
  assign layer_en       = live_flat[4*SCROLL_W +: LAYER_W];
  assign commit_pending = pending;
endmodule

// File: rtl/vcs_checker.sv
module vcs_checker
  import vcs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SCROLL_W = 9,
  parameter int LAYER_W  = 3,
  localparam int TOT_W   = NUM_SCROLL * SCROLL_W + LAYER_W
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              dma_done,
  input logic                              vblank,
  input logic                              wr_ready,
  input logic                              commit_pending,
  input logic [NUM_FIELDS-1:0][DATA_W-1:0] stage_q,
  input logic [TOT_W-1:0]                  live_flat
);
  logic [TOT_W-1:0] stage_packed;
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_pack
    localparam int W = (i < NUM_SCROLL) ? SCROLL_W : LAYER_W;
    assign stage_packed[i*SCROLL_W +: W] = stage_q[i][W-1:0];
  end

  AST_LIVE_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(live_flat)); // R3
  AST_NO_COMMIT_WITHOUT_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_pending && !dma_done) |=> $stable(live_flat)); // R4
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done && !vblank) |=> commit_pending); // R5
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> !commit_pending); // R6
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && (commit_pending || dma_done)) |=> (live_flat == $past(stage_packed))); // R8
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready); // R9
endmodule

bind vid_ctrl_shadow vcs_checker #(.DATA_W(DATA_W), .SCROLL_W(SCROLL_W), .LAYER_W(LAYER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_done(dma_done), .vblank(vblank), .wr_ready(wr_ready),
  .commit_pending(commit_pending), .stage_q(stage_q), .live_flat(live_flat)
);

// File: tb/vid_ctrl_shadow_tb.sv
`timescale 1ns/1ps
module vid_ctrl_shadow_tb;
  localparam int DW = 32, AW = 8, SW = 9, LW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, dma_done = 1'b0, vblank = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, commit_pending;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] bgx, bgy, fgx, fgy;
  logic [LW-1:0] len;

  int checks = 0, fails = 0;
  int exp_stage [5];
  int exp_live  [5];
  bit exp_pend;

  always #5 clk = ~clk;

  vid_ctrl_shadow #(.DATA_W(DW), .ADDR_W(AW), .SCROLL_W(SW), .LAYER_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dma_done(dma_done), .vblank(vblank),
    .bg_scroll_x(bgx), .bg_scroll_y(bgy), .fg_scroll_x(fgx), .fg_scroll_y(fgy),
    .layer_en(len), .commit_pending(commit_pending)
  );

  function automatic int fmask(int f);
    return (f < 4) ? ((1 << SW) - 1) : ((1 << LW) - 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_live(string req);
    chk(int'(bgx) == exp_live[0], req, int'(bgx), exp_live[0]);
    chk(int'(bgy) == exp_live[1], req, int'(bgy), exp_live[1]);
    chk(int'(fgx) == exp_live[2], req, int'(fgx), exp_live[2]);
    chk(int'(fgy) == exp_live[3], req, int'(fgy), exp_live[3]);
    chk(int'(len) == exp_live[4], req, int'(len), exp_live[4]);
    chk(commit_pending == exp_pend, req, int'(commit_pending), int'(exp_pend));
    chk(wr_ready == 1'b1, "R9", int'(wr_ready), 1);
  endtask

  task automatic read_chk(int a, int exp, string req);
    rd_addr = AW'(a);
    #1;
    chk(int'(rd_data) == exp, req, int'(rd_data), exp);
  endtask

  task automatic check_stage(string req);
    for (int f = 0; f < 5; f++) read_chk(f * 4, exp_stage[f], req);
    read_chk(20, int'(exp_pend), req);
  endtask

  task automatic step(bit wv, int a, int d, bit dma, bit vb, string req);
    bit cm;
    int idx;
    @(negedge clk);
    wr_valid = wv; wr_addr = AW'(a); wr_data = DW'(d); dma_done = dma; vblank = vb;
    @(posedge clk);
    cm = vb && (exp_pend || dma);
    if (cm) for (int f = 0; f < 5; f++) exp_live[f] = exp_stage[f];
    if (cm) exp_pend = 1'b0;
    else if (dma && !vb) exp_pend = 1'b1;
    idx = a >> 2;
    if (wv && (a % 4 == 0) && idx < 5) exp_stage[idx] = d & fmask(idx);
    #2;
    check_live(req);
  endtask

  task automatic idle(bit vb);
    step(1'b0, 0, 0, 1'b0, vb, "R3");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    for (int f = 0; f < 5; f++) begin exp_stage[f] = 0; exp_live[f] = 0; end
    exp_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check_live("R1");
    check_stage("R1");

    // R2: every value of every field, junk in the upper bits, live untouched
    for (int f = 0; f < 5; f++) begin
      for (int v = 0; v <= fmask(f); v++) begin
        step(1'b1, f * 4, v | 32'h5A5A_0000 | ((v * 7) << (f < 4 ? SW : LW)), 1'b0, 1'b0, "R2");
        read_chk(f * 4, v, "R2");
      end
    end

    // load known pattern
    for (int f = 0; f < 5; f++) step(1'b1, f * 4, (f * 97 + 13) & fmask(f), 1'b0, 1'b0, "R2");

    // R7: sweep all byte addresses
    for (int a = 0; a < 256; a++) begin
      if (!((a % 4 == 0) && (a / 4) < 5)) begin
        step(1'b1, a, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7");
        if (a == 20) read_chk(a, int'(exp_pend), "R7");
        else read_chk(a, 0, "R7");
      end
    end
    check_stage("R7");

    // R4: blanking without a DMA pulse
    repeat (4) idle(1'b1);
    check_live("R4");

    // R5: mid-frame pulse, hold through the frame, commit at blanking
    for (int k = 0; k < 6; k++) begin
      for (int f = 0; f < 5; f++)
        step(1'b1, f * 4, (k * 37 + f * 11 + 5) & fmask(f), 1'b0, 1'b0, "R2");
      step(1'b0, 0, 0, 1'b1, 1'b0, "R5");
      read_chk(20, 1, "R5");
      step(1'b1, (k % 5) * 4, (k * 53 + 1) & fmask(k % 5), 1'b0, 1'b0, "R3");
      repeat (3) idle(1'b0);
      idle(1'b1);
      check_live("R5");
      read_chk(20, 0, "R5");
      idle(1'b1);
      idle(1'b0);
    end

    // R6: pulse during blanking commits at once, no pending
    step(1'b1, 8, 9'h1A5, 1'b0, 1'b1, "R2");
    step(1'b0, 0, 0, 1'b1, 1'b1, "R6");
    chk(int'(fgx) == 9'h1A5, "R6", int'(fgx), 9'h1A5);
    chk(commit_pending == 1'b0, "R6", int'(commit_pending), 0);

    // R8: write on the same edge as a commit
    step(1'b1, 0, 9'h0F0, 1'b0, 1'b0, "R2");
    step(1'b0, 0, 0, 1'b1, 1'b0, "R5");
    step(1'b1, 0, 9'h10F, 1'b0, 1'b1, "R8");
    chk(int'(bgx) == 9'h0F0, "R8", int'(bgx), 9'h0F0);
    read_chk(0, 9'h10F, "R8");
    idle(1'b1);
    chk(int'(bgx) == 9'h0F0, "R8", int'(bgx), 9'h0F0);
    step(1'b0, 0, 0, 1'b1, 1'b1, "R6");
    chk(int'(bgx) == 9'h10F, "R8", int'(bgx), 9'h10F);

    idle(1'b0);
    finish_run();
  end
endmodule